// File: doc/BRIEF.md
# Up-Down Coincidence Lock Detector

This block tells a synthesiser controller whether its phase-locked loop has settled. It watches the up and down correction pulses of a phase/frequency detector on a fast system clock. When the loop is locked, both pulses are very short, so they are seldom high together. When the loop is out of lock, their widths swing back and forth at the difference frequency of the two divider outputs, so they overlap often.

A saturating level counter stands in for an analog integrator. Every clock in which both pulses are high adds a programmable step to the level. Every other clock takes one away. A low and a high threshold with hysteresis turn the level into a lock decision. The decision is given as an active-high flag and as its active-low copy. The step size and the ceiling set how long lock takes to be declared. A large step makes loss of lock show up several times faster than lock is declared, and a short overlap during acquisition cannot raise a false lock.

Top module: `lkd_lock_detect`

## Requirements
- R1: While rst_ni is low at a rising clock edge, that edge loads level_o with max_i and clears lock_o.
- R2: A clock edge at which up_i and dn_i are both high raises level_o by step_i. If the sum would reach or pass max_i, level_o becomes max_i.
- R3: A clock edge at which up_i and dn_i are not both high lowers level_o by one. A level of zero stays at zero.
- R4: While unlocked, lock_o rises at the edge after one that leaves level_o strictly below lo_thr_i. A level at or above lo_thr_i keeps the block unlocked.
- R5: While locked, lock_o falls at the edge after one that leaves level_o strictly above hi_thr_i. A level inside lo_thr_i..hi_thr_i leaves lock_o unchanged.
- R6: lock_no is always the inverse of lock_o.
- R7: level_o never exceeds max_i, whatever the step size.
- R8: With lo_thr_i <= hi_thr_i < max_i and the settings held constant, two latencies are fixed. After reset with no overlap, lock_o rises on the (max_i - lo_thr_i + 2)-th edge. From a locked level of zero with constant overlap, lock_o falls on the (ceil((hi_thr_i + 1) / step_i) + 1)-th edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| up_i | input | 1 | Up correction pulse from the phase detector |
| dn_i | input | 1 | Down correction pulse from the phase detector |
| step_i | input | STEP_W | Amount added to the level per overlap clock |
| max_i | input | CNT_W | Level ceiling and reset value |
| lo_thr_i | input | CNT_W | Level below which lock is declared |
| hi_thr_i | input | CNT_W | Level above which lock is dropped |
| level_o | output | CNT_W | Current filter level |
| lock_o | output | 1 | High while locked |
| lock_no | output | 1 | Low while locked |

## Verification
The bench measures how many edges lock takes to rise after reset and to fall from a settled lock. A design that is off by one in its threshold compare or its state register misses both counts, and one with the wrong step weighting misses the ratio between them. Directed cases hold the level inside the hysteresis band from both sides. A design without hysteresis would chatter there. A step of 15 against a ceiling of 15 checks that the sum is clamped before it wraps, and long runs of no overlap check that the level stops at zero instead of wrapping to the top. Random narrow-pulse and beating patterns, checked cycle by cycle against a bench model, catch any edge where the level or the lock state drifts from the rules.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
  typedef enum logic {
    ST_UNLOCKED = 1'b0,
    ST_LOCKED   = 1'b1
  } lk_state_e;
endpackage

// File: rtl/lkd_coin_det.sv
module lkd_coin_det (
  input  logic up_i,
  input  logic dn_i,
  output logic coin_o,
  output logic quiet_o
);
  // Overlap of both correction pulses marks a cycle that points to lost lock
  assign coin_o  = up_i & dn_i;
  assign quiet_o = ~(up_i & dn_i);
endmodule

// File: rtl/lkd_level_ctr.sv
module lkd_level_ctr #(
  parameter int CNT_W  = 12,
  parameter int STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              coin_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [CNT_W-1:0]  max_i,
  output logic [CNT_W-1:0]  level_o,
  output logic              clamp_o
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] level_q;
  logic [CNT_W-1:0] level_d;

  // Sum one bit wider so a large step cannot wrap past the ceiling
  function automatic logic [SUM_W-1:0] widen_sum(input logic [CNT_W-1:0] lvl,
                                                 input logic [STEP_W-1:0] stp);
    return {1'b0, lvl} + SUM_W'(stp);
  endfunction

  function automatic logic [CNT_W-1:0] next_level(input logic              coin,
                                                  input logic [CNT_W-1:0]  lvl,
                                                  input logic [STEP_W-1:0] stp,
                                                  input logic [CNT_W-1:0]  ceil_v);
    logic [SUM_W-1:0] s;
    s = widen_sum(lvl, stp);
    if (coin) begin
      if (s >= {1'b0, ceil_v}) return ceil_v;
      else                     return s[CNT_W-1:0];
    end else begin
      if (lvl == '0) return '0;
      else           return lvl - CNT_W'(1);
    end
  endfunction

  assign level_d = next_level(coin_i, level_q, step_i, max_i);
  assign clamp_o = coin_i && (widen_sum(level_q, step_i) >= {1'b0, max_i});

  always_ff @(posedge clk_i) begin
    if (!rst_ni) level_q <= max_i;
    else         level_q <= level_d;
  end

  assign level_o = level_q;
endmodule

// File: rtl/lkd_hyst.sv
module lkd_hyst #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] level_i,
  input  logic [CNT_W-1:0] lo_thr_i,
  input  logic [CNT_W-1:0] hi_thr_i,
  output logic             arm_o,
  output logic             trip_o,
  output logic             lock_o
);
  import lkd_pkg::*;

  lk_state_e state_q;
  lk_state_e state_d;

  function automatic logic below_lo(input logic [CNT_W-1:0] lvl,
                                    input logic [CNT_W-1:0] thr);
    return lvl < thr;
  endfunction

  function automatic logic above_hi(input logic [CNT_W-1:0] lvl,
                                    input logic [CNT_W-1:0] thr);
    return lvl > thr;
  endfunction

  assign arm_o  = below_lo(level_i, lo_thr_i);
  assign trip_o = above_hi(level_i, hi_thr_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_UNLOCKED: if (arm_o)  state_d = ST_LOCKED;
      ST_LOCKED:   if (trip_o) state_d = ST_UNLOCKED;
      default:     state_d = ST_UNLOCKED;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) state_q <= ST_UNLOCKED;
    else         state_q <= state_d;
  end

  assign lock_o = (state_q == ST_LOCKED);
endmodule

// File: rtl/lkd_lock_detect.sv
module lkd_lock_detect #(
  parameter int CNT_W  = 12,
  parameter int STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              up_i,
  input  logic              dn_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [CNT_W-1:0]  max_i,
  input  logic [CNT_W-1:0]  lo_thr_i,
  input  logic [CNT_W-1:0]  hi_thr_i,
  output logic [CNT_W-1:0]  level_o,
  output logic              lock_o,
  output logic              lock_no
);
  // Named internal events, brought out for the checker
  logic             coin_w;
  logic             quiet_w;
  logic             clamp_w;
  logic             arm_w;
  logic             trip_w;
  logic [CNT_W-1:0] level_w;
  logic             lock_w;

  lkd_coin_det u_coin (
    .up_i    (up_i),
    .dn_i    (dn_i),
    .coin_o  (coin_w),
    .quiet_o (quiet_w)
  );

  lkd_level_ctr #(
    .CNT_W  (CNT_W),
    .STEP_W (STEP_W)
  ) u_level (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .coin_i  (coin_w),
    .step_i  (step_i),
    .max_i   (max_i),
    .level_o (level_w),
    .clamp_o (clamp_w)
  );

  lkd_hyst #(
    .CNT_W (CNT_W)
  ) u_hyst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .level_i  (level_w),
    .lo_thr_i (lo_thr_i),
    .hi_thr_i (hi_thr_i),
    .arm_o    (arm_w),
    .trip_o   (trip_w),
    .lock_o   (lock_w)
  );

  assign level_o = level_w;
  assign lock_o  = lock_w;
  assign lock_no = ~lock_w;
endmodule

// File: rtl/lkd_lock_detect_chk.sv
module lkd_lock_detect_chk #(
  parameter int CNT_W  = 12,
  parameter int STEP_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              coin_w,
  input logic              quiet_w,
  input logic              arm_w,
  input logic              trip_w,
  input logic [STEP_W-1:0] step_i,
  input logic [CNT_W-1:0]  max_i,
  input logic [CNT_W-1:0]  lo_thr_i,
  input logic [CNT_W-1:0]  hi_thr_i,
  input logic [CNT_W-1:0]  level_o,
  input logic              lock_o,
  input logic              lock_no
);
  AST_RESET_STATE: assert property (@(posedge clk_i)
    !rst_ni |=> (level_o == $past(max_i)) && !lock_o); // R1

  AST_OVERLAP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coin_w |=> (level_o == $past(max_i)) ||
               (level_o == $past(level_o) + CNT_W'($past(step_i)))); // R2

  AST_QUIET_DECR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_w && level_o != '0) |=> level_o == $past(level_o) - CNT_W'(1)); // R3

  AST_FLOOR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_w && level_o == '0) |=> level_o == '0); // R3

  AST_LOCK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(level_o) < $past(lo_thr_i)); // R4

  AST_ARM_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_w |=> lock_o); // R4

  AST_LOCK_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> $past(level_o) > $past(hi_thr_i)); // R5

  AST_BAND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !trip_w) |=> lock_o); // R5

  AST_LOCK_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_no == !lock_o); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coin_w |=> level_o <= $past(max_i)); // R7
endmodule

bind lkd_lock_detect lkd_lock_detect_chk #(
  .CNT_W  (CNT_W),
  .STEP_W (STEP_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .coin_w   (coin_w),
  .quiet_w  (quiet_w),
  .arm_w    (arm_w),
  .trip_w   (trip_w),
  .step_i   (step_i),
  .max_i    (max_i),
  .lo_thr_i (lo_thr_i),
  .hi_thr_i (hi_thr_i),
  .level_o  (level_o),
  .lock_o   (lock_o),
  .lock_no  (lock_no)
);

// File: tb/lkd_lock_detect_tb.sv
module lkd_lock_detect_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 12;
  localparam int STEP_W     = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              up_i, dn_i;
  logic [STEP_W-1:0] step_i;
  logic [CNT_W-1:0]  max_i, lo_thr_i, hi_thr_i;
  logic [CNT_W-1:0]  level_o;
  logic              lock_o, lock_no;

  int checks = 0;
  int errors = 0;
  int exp_lvl = 0;
  bit exp_lk  = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lkd_lock_detect #(.CNT_W(CNT_W), .STEP_W(STEP_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .up_i(up_i), .dn_i(dn_i),
    .step_i(step_i), .max_i(max_i), .lo_thr_i(lo_thr_i), .hi_thr_i(hi_thr_i),
    .level_o(level_o), .lock_o(lock_o), .lock_no(lock_no)
  );

  // Reference rules, written from the requirements
  function automatic int ref_level(bit rst_n, bit both, int lvl, int stp, int top);
    if (!rst_n) return top;
    if (both)   return (lvl + stp > top) ? top : lvl + stp;
    return (lvl > 0) ? lvl - 1 : 0;
  endfunction

  function automatic bit ref_lock(bit rst_n, bit lk, int lvl, int lo, int hi);
    if (!rst_n) return 1'b0;
    if (!lk)    return lvl < lo;
    return !(lvl > hi);
  endfunction

  function automatic int ceil_div(int a, int b);
    return (a + b - 1) / b;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(bit r, bit u, bit d);
    bit both;
    int old_lvl;
    @(negedge clk_i);
    rst_ni = r; up_i = u; dn_i = d;
    @(posedge clk_i);
    both    = u & d;
    old_lvl = exp_lvl;
    exp_lvl = ref_level(r, both, exp_lvl, int'(step_i), int'(max_i));
    exp_lk  = ref_lock(r, exp_lk, old_lvl, int'(lo_thr_i), int'(hi_thr_i));
    #1;
    if (!r)        check(level_o == CNT_W'(exp_lvl), "R1 level", int'(level_o), exp_lvl);
    else if (both) check(level_o == CNT_W'(exp_lvl), "R2 level", int'(level_o), exp_lvl);
    else           check(level_o == CNT_W'(exp_lvl), "R3 level", int'(level_o), exp_lvl);
    check(lock_o == exp_lk, "R4/R5 lock", int'(lock_o), int'(exp_lk));
    check(lock_no == !exp_lk, "R6 lock_n", int'(lock_no), int'(!exp_lk));
    check(int'(level_o) <= int'(max_i), "R7 ceiling", int'(level_o), int'(max_i));
  endtask

  task automatic do_reset();
    for (int i = 0; i < 2; i++) tick(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat_lock, lat_unlock, exp_ll, exp_ul;
    void'($urandom(32'd4242));
    rst_ni = 1'b0; up_i = 1'b0; dn_i = 1'b0;
    step_i = 4'd3; max_i = 12'd40; lo_thr_i = 12'd8; hi_thr_i = 12'd20;
    do_reset();
    // R1: reset state
    check(level_o == 12'd40 && !lock_o, "R1 reset state", int'(level_o), 40);

    // R8: lock latency under narrow non-overlapping pulses
    lat_lock = 0;
    for (int i = 0; i < 100 && !lock_o; i++) begin
      tick(1'b1, (i % 4) == 0, (i % 4) == 1);
      lat_lock++;
    end
    exp_ll = 40 - 8 + 2;
    check(lat_lock == exp_ll, "R8 lock latency", lat_lock, exp_ll);
    for (int i = 0; i < 12; i++) tick(1'b1, 1'b0, 1'b0);
    check(level_o == 0, "R3 floor at zero", int'(level_o), 0);

    // R5: hysteresis band keeps lock
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 1'b1);
    check(lock_o == 1'b1 && level_o == 12'd12, "R5 band holds lock", int'(lock_o), 1);
    for (int i = 0; i < 20; i++) tick(1'b1, 1'b0, 1'b0);

    // R8: unlock latency under constant overlap
    lat_unlock = 0;
    for (int i = 0; i < 100 && lock_o; i++) begin
      tick(1'b1, 1'b1, 1'b1);
      lat_unlock++;
    end
    exp_ul = ceil_div(20 + 1, 3) + 1;
    check(lat_unlock == exp_ul, "R8 unlock latency", lat_unlock, exp_ul);
    check(lat_lock > lat_unlock * 3, "R8 asymmetry", lat_lock, lat_unlock * 3);
    for (int i = 0; i < 10; i++) tick(1'b1, 1'b1, 1'b1);
    check(level_o == 12'd40, "R7 clamp at max", int'(level_o), 40);

    // R4: band from above keeps unlocked
    for (int i = 0; i < 30; i++) tick(1'b1, 1'b1, 1'b0);
    check(lock_o == 1'b0 && level_o == 12'd10, "R4 band holds unlock", int'(lock_o), 0);

    // Random: narrow locked pattern alternating with beating pattern
    for (int seg = 0; seg < 12; seg++) begin
      bit beat = seg[0];
      for (int i = 0; i < 300; i++) begin
        int ph = i % 16;
        int w  = 1 + ((i / 16) % 7);
        bit u, d;
        if (beat) begin
          u = ph < w;
          d = ph < (8 - w) || ($urandom % 8) == 0;
        end else begin
          u = (ph == 0);
          d = (ph == 0) ? (($urandom % 8) == 0) : (ph == 1);
        end
        tick(1'b1, u, d);
      end
    end

    // R7: step equal to ceiling
    step_i = 4'd15; max_i = 12'd15; lo_thr_i = 12'd2; hi_thr_i = 12'd9;
    do_reset();
    for (int i = 0; i < 20; i++) tick(1'b1, 1'b0, 1'b0);
    tick(1'b1, 1'b1, 1'b1);
    check(level_o == 12'd15, "R7 large step clamp", int'(level_o), 15);
    tick(1'b1, 1'b1, 1'b1);
    check(level_o == 12'd15, "R7 clamp repeat", int'(level_o), 15);
    for (int i = 0; i < 200; i++) tick(1'b1, ($urandom % 3) == 0, ($urandom % 3) == 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule